// File: doc/BRIEF.md
# Speculative Reorder Buffer Controller

This block keeps the program order of instructions that a speculating out-of-order core has issued but not yet retired. An issuing instruction claims the slot at the tail of a circular buffer; the slot number comes back to the issue logic at once and serves as the name of the instruction's result for the reservation stations and functional units. Finished results arrive on a shared result bus tagged with that slot number, and the matching entry is marked complete.

Retirement is strictly in order. The oldest entry leaves only once it is complete. A register-writing entry drives a register-file write port, a store drives a store request carrying the address captured at issue, and a branch retires silently unless its result marks it mispredicted. In that case the whole buffer is discarded in a single cycle and the pointers restart at slot zero. Reservation stations are represented only by a single "station free" input.

Top module: `rob_ctrl`

## Requirements
- R1: `issue_ready_o` is high exactly when `station_free_i` is high, fewer than DEPTH entries are held, and no flush is signalled in that cycle. An instruction is accepted when `issue_valid_i` and `issue_ready_o` are both high at a clock edge.
- R2: `issue_tag_o` is the slot the next accepted instruction will occupy. Accepted instructions get consecutive slots, and slot DEPTH-1 (15 by default) is followed by slot 0.
- R3: A result whose tag names a held entry marks that entry complete and stores its value and mispredict flag. A result whose tag names a free slot changes nothing: when that slot is later allocated, it still waits for its own result.
- R4: Only the oldest entry retires, and only once it is complete. Younger complete entries wait behind an incomplete oldest entry. At most one entry retires per cycle.
- R5: A retiring entry of kind 0 (register write) raises `rf_we_o` for exactly one cycle, with its destination on `rf_dst_o` and its result on `rf_data_o`.
- R6: A retiring entry of kind 1 (store) raises `st_req_o` for one cycle, with the address given at issue on `st_addr_o` and its result on `st_data_o`.
- R7: A retiring entry of kind 2 (branch) with a clear mispredict flag produces no write and no store. With the flag set, it raises `flush_o` for one cycle. In the next cycle `count_o` is 0 and `issue_tag_o` is 0, and every earlier tag is free.
- R8: The mispredict flag delivered with the result of a kind 0 or kind 1 entry has no effect: no flush occurs and the entry retires normally.
- R9: `count_o` is 0 after reset. It rises by one per accepted issue and falls by one per retirement, and it stays the same when both happen in one cycle.
- R10: A result can be written back in the same cycle in which a different entry retires, and both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Instruction offered for issue |
| issue_kind_i | input | 2 | 0 register write, 1 store, 2 branch |
| issue_dst_i | input | REG_W | Destination register |
| issue_addr_i | input | ADDR_W | Store address |
| station_free_i | input | 1 | A reservation station is available |
| issue_ready_o | output | 1 | Issue can be accepted this cycle |
| issue_tag_o | output | TAG_W | Slot given to the next accepted instruction |
| res_valid_i | input | 1 | Result bus carries a result |
| res_tag_i | input | TAG_W | Slot the result belongs to |
| res_value_i | input | DATA_W | Result value or store data |
| res_mispred_i | input | 1 | Branch outcome was mispredicted |
| rf_we_o | output | 1 | Register-file write at retirement |
| rf_dst_o | output | REG_W | Register written |
| rf_data_o | output | DATA_W | Value written |
| st_req_o | output | 1 | Store request at retirement |
| st_addr_o | output | ADDR_W | Store address |
| st_data_o | output | DATA_W | Store data |
| flush_o | output | 1 | Mispredicted branch retiring, buffer discarded |
| count_o | output | CNT_W | Entries held |

## Verification
Two pairs of events share a cycle. The first is a result written back to one entry while an older entry retires. The second is an issue request in the same cycle that a mispredicted branch flushes the buffer. Both are provoked by long random phases. One phase fills the buffer with few results and another drains it with many. A mixed phase then feeds frequent mispredicted branches while issue continues, and some results are aimed at free slots. A behavioural queue model predicts the write, store, flush, ready, tag and count outputs every cycle. It shows whether the concurrent result survived the retirement and whether the issue offered during the flush was refused.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2,
    KIND_RSVD   = 2'd3
  } kind_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
`timescale 1ns/1ps
module rob_ptr_ctrl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned TAG_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             retire_i,
  input  logic             flush_i,
  output logic [TAG_W-1:0] head_o,
  output logic [TAG_W-1:0] tail_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);

  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
    return (p == TAG_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (alloc_i)  tail_q <= bump(tail_q);
      if (retire_i) head_q <= bump(head_q);
      case ({alloc_i, retire_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = count_q;
  assign full_o  = (count_q == CNT_W'(DEPTH));

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> (count_q < CNT_W'(DEPTH)));

  a_r9_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |-> (count_q != '0));

  a_r9_ptr_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int'(tail_q) - int'(head_q) + int'(DEPTH)) % int'(DEPTH))
      == (int'(count_q) % int'(DEPTH)));

  a_r7_flush_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0 && head_q == '0 && tail_q == '0));

endmodule

// File: rtl/rob_entries.sv
`timescale 1ns/1ps
module rob_entries
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned TAG_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              alloc_i,
  input  logic [TAG_W-1:0]  tail_i,
  input  kind_e             alloc_kind_i,
  input  logic [REG_W-1:0]  alloc_dst_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic              res_valid_i,
  input  logic [TAG_W-1:0]  res_tag_i,
  input  logic [DATA_W-1:0] res_value_i,
  input  logic              res_mispred_i,
  input  logic              retire_i,
  input  logic [TAG_W-1:0]  head_i,
  output logic              head_valid_o,
  output logic              head_done_o,
  output kind_e             head_kind_o,
  output logic [REG_W-1:0]  head_dst_o,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic [DATA_W-1:0] head_value_o,
  output logic              head_mispred_o
);

  logic              valid_q [DEPTH];
  logic              done_q  [DEPTH];
  kind_e             kind_q  [DEPTH];
  logic [REG_W-1:0]  dst_q   [DEPTH];
  logic [ADDR_W-1:0] addr_q  [DEPTH];
  logic [DATA_W-1:0] value_q [DEPTH];
  logic              mis_q   [DEPTH];

  logic res_hit;
  assign res_hit = res_valid_i && (int'(res_tag_i) < int'(DEPTH)) && valid_q[res_tag_i];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        done_q[i]  <= 1'b0;
        kind_q[i]  <= KIND_REG;
        dst_q[i]   <= '0;
        addr_q[i]  <= '0;
        value_q[i] <= '0;
        mis_q[i]   <= 1'b0;
      end else if (flush_i) begin
        valid_q[i] <= 1'b0;
        done_q[i]  <= 1'b0;
      end else begin
        if (retire_i && head_i == TAG_W'(i)) valid_q[i] <= 1'b0;
        if (res_hit && res_tag_i == TAG_W'(i)) begin
          done_q[i]  <= 1'b1;
          value_q[i] <= res_value_i;
          mis_q[i]   <= res_mispred_i;
        end
        // allocation lands on a free slot and wins over anything above
        if (alloc_i && tail_i == TAG_W'(i)) begin
          valid_q[i] <= 1'b1;
          done_q[i]  <= 1'b0;
          kind_q[i]  <= alloc_kind_i;
          dst_q[i]   <= alloc_dst_i;
          addr_q[i]  <= alloc_addr_i;
          mis_q[i]   <= 1'b0;
        end
      end
    end
  end

  assign head_valid_o   = valid_q[head_i];
  assign head_done_o    = done_q[head_i];
  assign head_kind_o    = kind_q[head_i];
  assign head_dst_o     = dst_q[head_i];
  assign head_addr_o    = addr_q[head_i];
  assign head_value_o   = value_q[head_i];
  assign head_mispred_o = mis_q[head_i];

  a_r3_result_marks_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_hit && !flush_i) |=> done_q[$past(res_tag_i)]);

  a_r3_alloc_into_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !valid_q[tail_i]);

endmodule

// File: rtl/rob_retire.sv
`timescale 1ns/1ps
module rob_retire
  import rob_pkg::*;
(
  input  logic  head_valid_i,
  input  logic  head_done_i,
  input  kind_e head_kind_i,
  input  logic  head_mispred_i,
  output logic  retire_o,
  output logic  rf_we_o,
  output logic  st_req_o,
  output logic  flush_o
);

  always_comb begin
    retire_o = head_valid_i && head_done_i;
    rf_we_o  = 1'b0;
    st_req_o = 1'b0;
    flush_o  = 1'b0;
    if (retire_o) begin
      unique case (head_kind_i)
        KIND_REG:    rf_we_o  = 1'b1;
        KIND_STORE:  st_req_o = 1'b1;
        KIND_BRANCH: flush_o  = head_mispred_i;
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/rob_ctrl.sv
`timescale 1ns/1ps
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned TAG_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [1:0]        issue_kind_i,
  input  logic [REG_W-1:0]  issue_dst_i,
  input  logic [ADDR_W-1:0] issue_addr_i,
  input  logic              station_free_i,
  output logic              issue_ready_o,
  output logic [TAG_W-1:0]  issue_tag_o,
  input  logic              res_valid_i,
  input  logic [TAG_W-1:0]  res_tag_i,
  input  logic [DATA_W-1:0] res_value_i,
  input  logic              res_mispred_i,
  output logic              rf_we_o,
  output logic [REG_W-1:0]  rf_dst_o,
  output logic [DATA_W-1:0] rf_data_o,
  output logic              st_req_o,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic [DATA_W-1:0] st_data_o,
  output logic              flush_o,
  output logic [CNT_W-1:0]  count_o
);

  logic [TAG_W-1:0]  head, tail;
  logic              full, fire, retire, flush;
  logic              head_valid, head_done, head_mis;
  kind_e             head_kind;
  logic [REG_W-1:0]  head_dst;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_value;

  assign issue_ready_o = station_free_i && !full && !flush;
  assign fire          = issue_valid_i && issue_ready_o;
  assign issue_tag_o   = tail;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .alloc_i  (fire),
    .retire_i (retire),
    .flush_i  (flush),
    .head_o   (head),
    .tail_o   (tail),
    .count_o  (count_o),
    .full_o   (full)
  );

  rob_entries #(
    .DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_entries (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .flush_i        (flush),
    .alloc_i        (fire),
    .tail_i         (tail),
    .alloc_kind_i   (kind_e'(issue_kind_i)),
    .alloc_dst_i    (issue_dst_i),
    .alloc_addr_i   (issue_addr_i),
    .res_valid_i    (res_valid_i),
    .res_tag_i      (res_tag_i),
    .res_value_i    (res_value_i),
    .res_mispred_i  (res_mispred_i),
    .retire_i       (retire),
    .head_i         (head),
    .head_valid_o   (head_valid),
    .head_done_o    (head_done),
    .head_kind_o    (head_kind),
    .head_dst_o     (head_dst),
    .head_addr_o    (head_addr),
    .head_value_o   (head_value),
    .head_mispred_o (head_mis)
  );

  rob_retire u_retire (
    .head_valid_i   (head_valid),
    .head_done_i    (head_done),
    .head_kind_i    (head_kind),
    .head_mispred_i (head_mis),
    .retire_o       (retire),
    .rf_we_o        (rf_we_o),
    .st_req_o       (st_req_o),
    .flush_o        (flush)
  );

  assign flush_o   = flush;
  assign rf_dst_o  = head_dst;
  assign rf_data_o = head_value;
  assign st_addr_o = head_addr;
  assign st_data_o = head_value;

  a_r5_one_action: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rf_we_o, st_req_o, flush_o}));

  a_r4_head_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != '0) |-> head_valid);

  a_r4_empty_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0) |-> !(rf_we_o || st_req_o || flush_o));

  a_r7_flush_refuses_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (count_o == '0 && issue_tag_o == '0));

endmodule

// File: tb/rob_ctrl_tb_top.sv
`timescale 1ns/1ps
module rob_ctrl_tb_top;
  localparam int DEPTH = 16;
  localparam int REG_W = 5;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int TAG_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic              issue_valid = 0;
  logic [1:0]        issue_kind = 0;
  logic [REG_W-1:0]  issue_dst = 0;
  logic [ADDR_W-1:0] issue_addr = 0;
  logic              station_free = 0;
  logic              issue_ready;
  logic [TAG_W-1:0]  issue_tag;
  logic              res_valid = 0;
  logic [TAG_W-1:0]  res_tag = 0;
  logic [DATA_W-1:0] res_value = 0;
  logic              res_mispred = 0;
  logic              rf_we, st_req, flush;
  logic [REG_W-1:0]  rf_dst;
  logic [DATA_W-1:0] rf_data, st_data;
  logic [ADDR_W-1:0] st_addr;
  logic [CNT_W-1:0]  count;

  rob_ctrl #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .issue_valid_i(issue_valid), .issue_kind_i(issue_kind), .issue_dst_i(issue_dst),
    .issue_addr_i(issue_addr), .station_free_i(station_free),
    .issue_ready_o(issue_ready), .issue_tag_o(issue_tag),
    .res_valid_i(res_valid), .res_tag_i(res_tag), .res_value_i(res_value),
    .res_mispred_i(res_mispred),
    .rf_we_o(rf_we), .rf_dst_o(rf_dst), .rf_data_o(rf_data),
    .st_req_o(st_req), .st_addr_o(st_addr), .st_data_o(st_data),
    .flush_o(flush), .count_o(count)
  );

  typedef struct {
    int tag; int kind; int dst; int addr; bit done; int val; bit mis;
  } ent_t;

  ent_t q[$];
  int   tail_m = 0;
  int   n_chk = 0;
  int   n_err = 0;
  int   saw_full = 0;
  int   saw_flush_issue = 0;
  int   saw_res_retire = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int p_issue, input int p_res, input int p_mis, input int p_stray);
    bit h_ret, e_flush, e_rf, e_st, e_ready;
    int pend[$];
    ent_t n;
    @(negedge clk);
    station_free = ($urandom_range(99) < 85);
    issue_valid  = ($urandom_range(99) < p_issue);
    issue_kind   = 2'($urandom_range(2));
    issue_dst    = REG_W'($urandom);
    issue_addr   = ADDR_W'($urandom);
    res_valid    = 1'b0;
    res_mispred  = ($urandom_range(99) < p_mis);
    res_value    = $urandom;
    foreach (q[i]) if (!q[i].done) pend.push_back(i);
    if ($urandom_range(99) < p_res) begin
      if (q.size() < DEPTH && $urandom_range(99) < p_stray) begin
        res_valid = 1'b1;
        res_tag   = TAG_W'(tail_m);
      end else if (pend.size() > 0) begin
        res_valid = 1'b1;
        res_tag   = TAG_W'(q[pend[$urandom_range(pend.size() - 1)]].tag);
      end
    end
    #1;
    h_ret   = (q.size() > 0) && q[0].done;
    e_flush = h_ret && q[0].kind == 2 && q[0].mis;
    e_rf    = h_ret && q[0].kind == 0;
    e_st    = h_ret && q[0].kind == 1;
    e_ready = station_free && q.size() < DEPTH && !e_flush;
    chk("R1 issue_ready", 64'(issue_ready), 64'(e_ready));
    chk("R2 issue_tag", 64'(issue_tag), 64'(tail_m));
    chk("R9 count", 64'(count), 64'(q.size()));
    chk("R4/R5 rf_we", 64'(rf_we), 64'(e_rf));
    chk("R6 st_req", 64'(st_req), 64'(e_st));
    chk("R7/R8 flush", 64'(flush), 64'(e_flush));
    if (e_rf) begin
      chk("R5 rf_dst", 64'(rf_dst), 64'(q[0].dst));
      chk("R5 rf_data", 64'(rf_data), 64'(unsigned'(q[0].val)));
    end
    if (e_st) begin
      chk("R6 st_addr", 64'(st_addr), 64'(q[0].addr));
      chk("R6 st_data", 64'(st_data), 64'(unsigned'(q[0].val)));
    end
    if (q.size() == DEPTH) saw_full++;
    if (e_flush && issue_valid && station_free) saw_flush_issue++;
    // next state of the reference model
    if (e_flush) begin
      q.delete();
      tail_m = 0;
    end else begin
      if (res_valid) begin
        foreach (q[i]) if (q[i].tag == int'(res_tag)) begin
          q[i].done = 1; q[i].val = int'(res_value); q[i].mis = res_mispred;
          if (h_ret && i != 0) saw_res_retire++;   // R10
        end
      end
      if (h_ret) void'(q.pop_front());
      if (issue_valid && e_ready) begin
        n.tag = tail_m; n.kind = int'(issue_kind); n.dst = int'(issue_dst);
        n.addr = int'(issue_addr); n.done = 0; n.val = 0; n.mis = 0;
        q.push_back(n);
        tail_m = (tail_m + 1) % DEPTH;
      end
    end
  endtask

  initial begin
    station_free = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset count", 64'(count), 64'd0);
    chk("R1 reset ready", 64'(issue_ready), 64'd1);
    chk("R2 reset tag", 64'(issue_tag), 64'd0);
    chk("R4 reset quiet", 64'({rf_we, st_req, flush}), 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int c = 0; c < 600; c++)  step(90, 15, 0, 20);
    for (int c = 0; c < 600; c++)  step(20, 85, 10, 10);
    for (int c = 0; c < 1500; c++) step(60, 60, 20, 15);
    for (int c = 0; c < 300; c++)  step(95, 40, 30, 10);
    n_chk++;
    if (saw_full == 0 || saw_flush_issue == 0 || saw_res_retire == 0) begin
      n_err++;
      $display("FAIL R1/R7/R10 coverage: actual %0d/%0d/%0d expected nonzero",
               saw_full, saw_flush_issue, saw_res_retire);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule